// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Thresholds

This block is a first-in first-out buffer for 9-bit words. The write port and the read port each have their own clock, and the two clocks may be one shared clock or fully unrelated. A word is accepted only when both enables of its port are high. Each pointer crosses to the other clock domain as a Gray code through a chain of synchronizer flops. Empty and almost-empty are derived in the read domain, and full and almost-full in the write domain.

The two threshold flags compare the fill level against offsets that software can set. Each offset resets to 7. To change them, hold the load input high and write words through the write port. Those words go to four offset halves in a fixed rotation and never enter the queue. The read data bus can be released to high impedance through an output-enable input. The storage depth is a parameter. Elaboration accepts powers of two from 256 to 8192.

Top module: `fifo9_dc`

## Requirements
- R1: A word on `din` is stored at a rising `wclk` edge when `wen_a` and `wen_b` are both high, `load` is low and `full` is low. Words leave in the order they were stored.
- R2: When `ren_a` and `ren_b` are both high and `empty` is low, the next stored word appears in the output register after the rising `rclk` edge. Otherwise the output register holds its value.
- R3: With `oe` low the `dq` bus is high impedance. With `oe` high, `dq` shows the output register.
- R4: Once both ports have been idle for four cycles, `empty` is high exactly when no words are held and `full` is high exactly when DEPTH words are held.
- R5: After the same settling, `almost_empty` is high exactly when the word count is less than or equal to the almost-empty offset.
- R6: After the same settling, `almost_full` is high exactly when DEPTH minus the word count is less than or equal to the almost-full offset.
- R7: A write while `full` is high and a read while `empty` is high are both ignored. Neither changes the stored words nor the output register.
- R8: While `load` is high, each write (both write enables high) goes to an offset half instead of the queue. The halves are written in the order: almost-empty low, almost-empty high, almost-full low, almost-full high, and then the rotation repeats. The rotation restarts at almost-empty low whenever `load` is low. Each offset is the low log2(DEPTH) bits of {high half, low half}, where each half is 9 bits.
- R9: A low `rst_n` empties the queue, clears the output register to 0 and restores both offsets to 7. After reset, `empty` and `almost_empty` are high, and `full` and `almost_full` are low.
- R10: If only one enable of a pair is high, that port does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for both domains |
| wclk | input | 1 | Write clock |
| wen_a | input | 1 | Write enable, first of pair |
| wen_b | input | 1 | Write enable, second of pair |
| load | input | 1 | Routes writes to the offset halves |
| din | input | 9 | Write data |
| full | output | 1 | Queue holds DEPTH words (write domain) |
| almost_full | output | 1 | Free space at or below the almost-full offset |
| rclk | input | 1 | Read clock |
| ren_a | input | 1 | Read enable, first of pair |
| ren_b | input | 1 | Read enable, second of pair |
| oe | input | 1 | Drives `dq` when high, releases it when low |
| dq | output | 9 | Read data, three-state |
| empty | output | 1 | Queue holds no words (read domain) |
| almost_empty | output | 1 | Word count at or below the almost-empty offset |

## Verification
The bench probes each threshold flag on both sides of its offset: at the default offsets, at loaded offsets, and after reset has restored them. A compare that is off by one shows up as a flag one word early or late. It writes into a full queue and reads from an empty one. A design that wrapped a pointer there would return a stray word or repeat an old one during the later drain. The bench loads five offset words to check that the rotation wraps back to the first half, and toggles `load` to check that the rotation restarts. A rotation that drifted would leave the almost-empty flag at the wrong fill level. A random phase uses single-enable cycles and back-to-back traffic to catch a port that fires on one enable or drops words.

// File: rtl/fifo9_pkg.sv
package fifo9_pkg;
   localparam int unsigned WORD_W   = 9;
   localparam int unsigned OFS_DFLT = 7;
   localparam int unsigned PTR_MAXW = 16;

   function automatic logic [PTR_MAXW-1:0] gray_to_bin(input logic [PTR_MAXW-1:0] g);
      logic [PTR_MAXW-1:0] b;
      b[PTR_MAXW-1] = g[PTR_MAXW-1];
      for (int i = PTR_MAXW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
      return b;
   endfunction
endpackage

// File: rtl/fifo9_sync.sv
module fifo9_sync #(
   parameter int unsigned W      = 9,
   parameter int unsigned STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[0] <= '0;
            else        chain[0] <= d;
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n)
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/fifo9_wr_ctl.sv
module fifo9_wr_ctl
   import fifo9_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic              wclk,
   input  logic              rst_n,
   input  logic              wen_a,
   input  logic              wen_b,
   input  logic              load,
   input  logic [WORD_W-1:0] din,
   input  logic [AW:0]       rd_gray_s,
   output logic [AW:0]       wr_bin,
   output logic [AW:0]       wr_gray,
   output logic              mem_we,
   output logic              full,
   output logic              almost_full,
   output logic [AW-1:0]     ae_ofs,
   output logic [AW-1:0]     af_ofs
);
   localparam logic [AW:0] DEPTH_V = (AW+1)'(DEPTH);
   localparam int unsigned CAT_W   = 2 * WORD_W;

   logic              both_en;
   logic [AW:0]       rd_bin_s, count_w, free_w, wr_next;
   logic [PTR_MAXW-1:0] rd_conv;
   logic [1:0]        ofs_idx;
   logic [WORD_W-1:0] ofs_half [4];
   logic [CAT_W-1:0]  ae_cat, af_cat;

   assign both_en  = wen_a & wen_b;
   assign rd_conv  = gray_to_bin(PTR_MAXW'(rd_gray_s));
   assign rd_bin_s = rd_conv[AW:0];
   assign count_w  = wr_bin - rd_bin_s;
   assign free_w   = DEPTH_V - count_w;
   assign full        = (count_w == DEPTH_V);
   assign almost_full = (free_w <= {1'b0, af_ofs});
   assign mem_we   = both_en & ~load & ~full;
   assign wr_next  = wr_bin + 1'b1;

   always_ff @(posedge wclk or negedge rst_n)
      if (!rst_n) begin
         wr_bin  <= '0;
         wr_gray <= '0;
      end else if (mem_we) begin
         wr_bin  <= wr_next;
         wr_gray <= wr_next ^ (wr_next >> 1);
      end

   // offset loader: rotation of four halves, restarts while load is low
   always_ff @(posedge wclk or negedge rst_n)
      if (!rst_n)             ofs_idx <= '0;
      else if (!load)         ofs_idx <= '0;
      else if (both_en)       ofs_idx <= ofs_idx + 2'd1;

   for (genvar h = 0; h < 4; h++) begin : g_half
      localparam logic [WORD_W-1:0] RST_V = ((h % 2) == 0) ? WORD_W'(OFS_DFLT) : '0;
      always_ff @(posedge wclk or negedge rst_n)
         if (!rst_n)                                   ofs_half[h] <= RST_V;
         else if (load && both_en && ofs_idx == 2'(h)) ofs_half[h] <= din;
   end

   assign ae_cat = {ofs_half[1], ofs_half[0]};
   assign af_cat = {ofs_half[3], ofs_half[2]};
   assign ae_ofs = AW'(ae_cat % CAT_W'(DEPTH));
   assign af_ofs = AW'(af_cat % CAT_W'(DEPTH));
endmodule

// File: rtl/fifo9_rd_ctl.sv
module fifo9_rd_ctl
   import fifo9_pkg::*;
#(
   parameter int unsigned DEPTH = 256,
   parameter int unsigned AW    = $clog2(DEPTH)
) (
   input  logic          rclk,
   input  logic          rst_n,
   input  logic          ren_a,
   input  logic          ren_b,
   input  logic [AW:0]   wr_gray_s,
   input  logic [AW-1:0] ae_ofs,
   output logic [AW:0]   rd_bin,
   output logic [AW:0]   rd_gray,
   output logic          rd_fire,
   output logic          empty,
   output logic          almost_empty
);
   logic [AW:0]         wr_bin_s, count_r, rd_next;
   logic [PTR_MAXW-1:0] wr_conv;

   assign wr_conv      = gray_to_bin(PTR_MAXW'(wr_gray_s));
   assign wr_bin_s     = wr_conv[AW:0];
   assign count_r      = wr_bin_s - rd_bin;
   assign empty        = (count_r == '0);
   assign almost_empty = (count_r <= {1'b0, ae_ofs});
   assign rd_fire      = ren_a & ren_b & ~empty;
   assign rd_next      = rd_bin + 1'b1;

   always_ff @(posedge rclk or negedge rst_n)
      if (!rst_n) begin
         rd_bin  <= '0;
         rd_gray <= '0;
      end else if (rd_fire) begin
         rd_bin  <= rd_next;
         rd_gray <= rd_next ^ (rd_next >> 1);
      end
endmodule

// File: rtl/fifo9_dc.sv
module fifo9_dc
   import fifo9_pkg::*;
#(
   parameter int unsigned DEPTH       = 256,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              rst_n,
   input  logic              wclk,
   input  logic              wen_a,
   input  logic              wen_b,
   input  logic              load,
   input  logic [WORD_W-1:0] din,
   output logic              full,
   output logic              almost_full,
   input  logic              rclk,
   input  logic              ren_a,
   input  logic              ren_b,
   input  logic              oe,
   output logic [WORD_W-1:0] dq,
   output logic              empty,
   output logic              almost_empty
);
   localparam int unsigned AW = $clog2(DEPTH);

   if (DEPTH != (1 << AW) || DEPTH < 256 || DEPTH > 8192) begin : g_bad_depth
      initial $fatal(1, "fifo9_dc: DEPTH must be a power of two from 256 to 8192");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      initial $fatal(1, "fifo9_dc: SYNC_STAGES must be at least 2");
   end

   logic [AW:0]       wr_bin, wr_gray, rd_bin, rd_gray, wr_gray_s, rd_gray_s;
   logic [AW-1:0]     ae_ofs, af_ofs;
   logic              mem_we, rd_fire;
   logic [WORD_W-1:0] mem [DEPTH];
   logic [WORD_W-1:0] dout_q;

   fifo9_wr_ctl #(.DEPTH(DEPTH), .AW(AW)) i_wr (
      .wclk(wclk), .rst_n(rst_n), .wen_a(wen_a), .wen_b(wen_b), .load(load),
      .din(din), .rd_gray_s(rd_gray_s), .wr_bin(wr_bin), .wr_gray(wr_gray),
      .mem_we(mem_we), .full(full), .almost_full(almost_full),
      .ae_ofs(ae_ofs), .af_ofs(af_ofs));

   fifo9_rd_ctl #(.DEPTH(DEPTH), .AW(AW)) i_rd (
      .rclk(rclk), .rst_n(rst_n), .ren_a(ren_a), .ren_b(ren_b),
      .wr_gray_s(wr_gray_s), .ae_ofs(ae_ofs), .rd_bin(rd_bin), .rd_gray(rd_gray),
      .rd_fire(rd_fire), .empty(empty), .almost_empty(almost_empty));

   fifo9_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) i_sync_w2r (
      .clk(rclk), .rst_n(rst_n), .d(wr_gray), .q(wr_gray_s));

   fifo9_sync #(.W(AW+1), .STAGES(SYNC_STAGES)) i_sync_r2w (
      .clk(wclk), .rst_n(rst_n), .d(rd_gray), .q(rd_gray_s));

   always_ff @(posedge wclk)
      if (mem_we) mem[wr_bin[AW-1:0]] <= din;

   always_ff @(posedge rclk or negedge rst_n)
      if (!rst_n)       dout_q <= '0;
      else if (rd_fire) dout_q <= mem[rd_bin[AW-1:0]];

   assign dq = oe ? dout_q : 'z;
endmodule

// File: rtl/fifo9_dc_chk.sv
module fifo9_dc_chk #(
   parameter int unsigned AW = 8
) (
   input logic          rst_n,
   input logic          wclk,
   input logic          rclk,
   input logic          wen_a,
   input logic          wen_b,
   input logic          load,
   input logic          ren_a,
   input logic          ren_b,
   input logic          full,
   input logic          almost_full,
   input logic          empty,
   input logic          almost_empty,
   input logic [AW:0]   wr_bin,
   input logic [AW:0]   rd_bin,
   input logic [8:0]    dout_q
);
   a_r1_wr_step: assert property (@(posedge wclk) disable iff (!rst_n)
      (wen_a && wen_b && !load && !full) |=> wr_bin == $past(wr_bin) + 1'b1);

   a_r7_no_overflow: assert property (@(posedge wclk) disable iff (!rst_n)
      (wen_a && wen_b && full) |=> $stable(wr_bin));

   a_r10_wr_single: assert property (@(posedge wclk) disable iff (!rst_n)
      !(wen_a && wen_b) |=> $stable(wr_bin));

   a_r8_load_no_push: assert property (@(posedge wclk) disable iff (!rst_n)
      load |=> $stable(wr_bin));

   a_r7_no_underflow: assert property (@(posedge rclk) disable iff (!rst_n)
      (ren_a && ren_b && empty) |=> $stable(rd_bin) && $stable(dout_q));

   a_r2_rd_hold: assert property (@(posedge rclk) disable iff (!rst_n)
      !(ren_a && ren_b) |=> $stable(dout_q) && $stable(rd_bin));

   a_r5_empty_implies_ae: assert property (@(posedge rclk) disable iff (!rst_n)
      empty |-> almost_empty);

   a_r6_full_implies_af: assert property (@(posedge wclk) disable iff (!rst_n)
      full |-> almost_full);
endmodule

bind fifo9_dc fifo9_dc_chk #(.AW(AW)) i_chk (.*);

// File: tb/test_fifo9_dc.sv
module test_fifo9_dc;
   localparam int DEPTH = 256;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wen_a = 0, wen_b = 0, load = 0, ren_a = 0, ren_b = 0, oe = 1;
   logic [8:0] din = '0;
   wire  [8:0] dq;
   logic       full, almost_full, empty, almost_empty;

   int errors = 0, checks = 0;
   logic [8:0] q[$];
   logic [8:0] last_rd = '0;
   int ae_o = 7, af_o = 7, ld_idx = 0;
   logic [8:0] half [4] = '{9'd7, 9'd0, 9'd7, 9'd0};

   always #4 clk = ~clk;

   for (genvar i = 0; i < 9; i++) begin : g_pu
      pullup (dq[i]);
   end

   fifo9_dc #(.DEPTH(DEPTH)) i_fifo9_dc (
      .rst_n(rst_n), .wclk(clk), .wen_a(wen_a), .wen_b(wen_b), .load(load),
      .din(din), .full(full), .almost_full(almost_full), .rclk(clk),
      .ren_a(ren_a), .ren_b(ren_b), .oe(oe), .dq(dq), .empty(empty),
      .almost_empty(almost_empty));

   task automatic check(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int ofs_of(logic [8:0] lo, logic [8:0] hi);
      return int'({hi, lo}) % DEPTH;
   endfunction

   task automatic idle(int n);
      repeat (n) begin
         @(negedge clk);
         wen_a = 0; wen_b = 0; ren_a = 0; ren_b = 0;
      end
   endtask

   task automatic push(logic [8:0] d);
      @(negedge clk);
      wen_a = 1; wen_b = 1; din = d;
      if (load) begin
         half[ld_idx] = d;
         ld_idx = (ld_idx + 1) % 4;
         ae_o = ofs_of(half[0], half[1]);
         af_o = ofs_of(half[2], half[3]);
      end else if (q.size() < DEPTH) q.push_back(d);
      @(negedge clk);
      wen_a = 0; wen_b = 0;
   endtask

   task automatic set_load(logic v);
      @(negedge clk);
      load = v;
      if (!v) ld_idx = 0;
   endtask

   task automatic pop_check(string req);
      @(negedge clk);
      ren_a = 1; ren_b = 1;
      if (q.size() > 0) last_rd = q.pop_front();
      @(negedge clk);
      ren_a = 0; ren_b = 0;
      check(req, int'(dq), int'(last_rd));
   endtask

   task automatic flags(string req);
      int n;
      idle(6);
      n = q.size();
      check({req, " R4 empty"}, int'(empty), int'(n == 0));
      check({req, " R4 full"}, int'(full), int'(n == DEPTH));
      check({req, " R5 almost_empty"}, int'(almost_empty), int'(n <= ae_o));
      check({req, " R6 almost_full"}, int'(almost_full), int'(DEPTH - n <= af_o));
   endtask

   task automatic fill_to(int n);
      while (q.size() < n) push(9'($urandom));
   endtask

   task automatic drain(string req);
      while (q.size() > 0) pop_check(req);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin : main
      void'($urandom(32'd20240611));
      idle(3);
      // R9 reset state
      check("R9 empty at reset", int'(empty), 1);
      check("R9 almost_empty at reset", int'(almost_empty), 1);
      check("R9 full at reset", int'(full), 0);
      check("R9 almost_full at reset", int'(almost_full), 0);
      check("R9 output register zero", int'(dq), 0);
      @(negedge clk); oe = 0;
      @(negedge clk);
      check("R3 dq released (pullup)", int'(dq), 9'h1FF);
      @(negedge clk); oe = 1;
      @(negedge clk); rst_n = 1;
      idle(2);

      // R5 default almost-empty boundary
      fill_to(7);  flags("R5 count7");
      fill_to(8);  flags("R5 count8");
      drain("R1 R2 order after small burst");
      flags("R4 drained");

      // R7 read while empty leaves output register
      pop_check("R7 read on empty holds output");
      flags("R7 empty after ignored read");

      // R10 single enables
      @(negedge clk); wen_a = 1; din = 9'h155;
      @(negedge clk); wen_a = 0; wen_b = 1;
      @(negedge clk); wen_b = 0;
      flags("R10 single write enable ignored");
      push(9'h0A5);
      idle(6);
      @(negedge clk); ren_a = 1;
      @(negedge clk); ren_a = 0;
      check("R10 single read enable ignored", int'(dq), int'(last_rd));
      pop_check("R10 word still there");

      // R6 / R4 / R7 around full
      fill_to(DEPTH - 8); flags("R6 free8");
      fill_to(DEPTH - 7); flags("R6 free7");
      fill_to(DEPTH);     flags("R4 full");
      push(9'h1AA);       flags("R7 write on full");
      drain("R7 R1 full drain order");
      flags("R4 empty after full drain");

      // R8 loader: ae=20, af=30
      set_load(1);
      push(9'd20); push(9'd0); push(9'd30); push(9'd0);
      set_load(0);
      flags("R8 loader words not queued");
      fill_to(20); flags("R8 ae20 at 20");
      fill_to(21); flags("R8 ae20 at 21");
      fill_to(DEPTH - 31); flags("R8 af30 free31");
      fill_to(DEPTH - 30); flags("R8 af30 free30");
      drain("R8 drain");

      // R8 rotation restarts while load low
      set_load(1); push(9'd5); set_load(0);
      set_load(1); push(9'd4); set_load(0);
      fill_to(4); flags("R8 restart ae4 at 4");
      fill_to(5); flags("R8 restart ae4 at 5");
      drain("R8 drain2");

      // R8 wrap after four halves, high half above AW ignored
      set_load(1);
      push(9'd3); push(9'd1); push(9'd8); push(9'd0); push(9'd2);
      set_load(0);
      fill_to(2); flags("R8 wrap ae2 at 2");
      fill_to(3); flags("R8 wrap ae2 at 3");
      fill_to(DEPTH - 9); flags("R8 af8 free9");
      fill_to(DEPTH - 8); flags("R8 af8 free8");
      drain("R8 drain3");

      // random mixed traffic, R1 R2 R10
      fill_to(100);
      idle(6);
      begin
         logic pend = 0;
         logic [8:0] exp_rd = '0;
         for (int c = 0; c < 4000; c++) begin
            @(negedge clk);
            if (pend) check("R2 random read data", int'(dq), int'(exp_rd));
            pend = 0;
            wen_a = ($urandom % 4) != 0; wen_b = ($urandom % 4) != 0;
            ren_a = ($urandom % 4) != 0; ren_b = ($urandom % 4) != 0;
            din = 9'($urandom);
            if (q.size() >= DEPTH - 16) wen_b = 0;
            if (q.size() <= 16) ren_b = 0;
            if (ren_a && ren_b) begin
               exp_rd = q.pop_front(); last_rd = exp_rd; pend = 1;
            end
            if (wen_a && wen_b) q.push_back(din);
         end
         @(negedge clk);
         wen_a = 0; wen_b = 0; ren_a = 0; ren_b = 0;
         if (pend) check("R2 random last read", int'(dq), int'(exp_rd));
      end
      flags("R4 after random");
      drain("R1 random drain");

      // R9 reset with data and loaded offsets
      fill_to(30);
      set_load(1); push(9'd40); set_load(0);
      @(negedge clk); rst_n = 0;
      q.delete(); ae_o = 7; af_o = 7; half = '{9'd7, 9'd0, 9'd7, 9'd0};
      @(negedge clk);
      check("R9 output cleared", int'(dq), 0);
      @(negedge clk); rst_n = 1;
      flags("R9 after reset");
      fill_to(7); flags("R9 default ae at 7");
      fill_to(8); flags("R9 default ae at 8");
      drain("R9 drain");

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule